// File: doc/BRIEF.md
# Serial Transmitter with Single-Character Holding Stage

This block turns parallel characters into an asynchronous serial bit stream. A host writes one character at a time into a holding register. Whenever the shift stage is free, the held character moves into it and is sent on the line. A frame is a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. Every bit lasts a fixed number of pulses of an external oversampling clock enable. By default that is 16 pulses, so the enable runs at sixteen times the baud rate.

A two-bit command input turns the transmitter on and off. Two flags report status. Ready means the holding register will take a character. Empty means that nothing is held and nothing is being shifted. When the transmitter is off, both flags read low and host writes are thrown away. A frame that is already on the line when the transmitter is turned off still finishes.

Top module: `stx_transmitter`

## Requirements
- R1: After reset the transmitter is disabled, `txd_o` is 1, and `tx_ready_o` and `tx_empty_o` are 0.
- R2: On `cmd_i`, 2'b01 enables the transmitter and 2'b10 disables it. The codes 2'b00 and 2'b11 change nothing. If an enable arrives while nothing is held or shifting, both `tx_ready_o` and `tx_empty_o` read 1 after the next clock edge.
- R3: A write (`wr_en_i` high at a clock edge) is accepted only while `tx_ready_o` is 1, and `tx_ready_o` reads 0 after that edge. A write made while `tx_ready_o` is 0 is dropped, and the character it carried never appears on the line.
- R4: If a character is held and the shift stage is idle, the character moves into the shift stage at the next clock edge. The start bit begins at that edge, and `tx_ready_o` returns to 1.
- R5: The frame on the line is:
  - one 0 start bit;
  - DATA_W data bits, least significant first;
  - when `par_en_i` is 1, a parity bit equal to the XOR of the data bits, further XORed with `par_odd_i`;
  - one stop bit, or two when `two_stop_i` is 1, each stop bit being 1.
  Each bit lasts OVERSAMPLE clock edges at which `baud16_en_i` is 1. Edges with `baud16_en_i` at 0 do not advance the frame.
- R6: A character that waits in the holding register starts its start bit at the same edge that ends the previous frame's last stop bit, so no idle time separates the two frames.
- R7: `tx_empty_o` rises at the edge that ends the last stop bit when no character is held. It reads 0 while a frame is shifting or a character is held.
- R8: After a disable command, `tx_ready_o` and `tx_empty_o` read 0 for as long as the transmitter stays disabled. A character already held is discarded, and writes made while disabled are ignored.
- R9: A frame that is shifting when a disable command arrives completes unchanged. After it, the line stays idle.
- R10: While no frame is shifting, `txd_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud16_en_i | input | 1 | Oversampling clock enable, OVERSAMPLE pulses per bit |
| cmd_i | input | 2 | Command: 01 enable, 10 disable, others no action |
| par_en_i | input | 1 | Append a parity bit |
| par_odd_i | input | 1 | Use odd parity instead of even |
| two_stop_i | input | 1 | Send two stop bits instead of one |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Character to send |
| txd_o | output | 1 | Serial line, idles high |
| tx_ready_o | output | 1 | Holding register can accept a character |
| tx_empty_o | output | 1 | Holding register and shift stage are both idle |

## Verification
The flags are registered, so a write, a command or a transfer into the shift stage shows on them one clock edge later. The bench therefore samples them at the falling edge right after the edge that acted. Line bits change only on an edge that carries the sixteenth counted enable of a bit. The bench counts enables from the edge where the character was loaded, samples every bit after eight enables, and checks the end of the frame, or the next start bit, at exactly OVERSAMPLE times the frame length. The enable is high only on every second cycle, which also checks that edges without an enable leave the frame where it is.

// File: rtl/stx_pkg.sv
package stx_pkg;

    // Command codes on cmd_i
    typedef enum logic [1:0] {
        CMD_NONE    = 2'b00,
        CMD_ENABLE  = 2'b01,
        CMD_DISABLE = 2'b10,
        CMD_RSVD    = 2'b11
    } stx_cmd_e;

endpackage

// File: rtl/stx_frame_builder.sv
module stx_frame_builder #(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 4,
    parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data_i,
    input  logic               par_en_i,
    input  logic               par_odd_i,
    input  logic               two_stop_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [LEN_W-1:0]   len_o
);

    // Bit 0 goes out first: start, data LSB first, parity, stop bits.
    // Every position not written below stays 1 and serves as a stop bit.
    always_comb begin
        frame_o             = '1;
        frame_o[0]          = 1'b0;
        frame_o[DATA_W:1]   = data_i;
        if (par_en_i) begin
            frame_o[DATA_W+1] = (^data_i) ^ par_odd_i;
        end
        len_o = LEN_W'(DATA_W + 2) + LEN_W'(par_en_i) + LEN_W'(two_stop_i);
    end

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
    parameter int FRAME_W    = 12,
    parameter int LEN_W      = 4,
    parameter int OVERSAMPLE = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] load_frame_i,
    input  logic [LEN_W-1:0]   load_len_i,
    output logic               txd_o,
    output logic               busy_o,
    output logic               frame_end_o
);

    localparam int              SUB_W    = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] frame;
        logic [LEN_W-1:0]   left;
        logic [SUB_W-1:0]   sub;
    } shift_state_t;

    shift_state_t sh_d, sh_q;
    logic         bit_done;

    always_comb begin
        sh_d        = sh_q;
        bit_done    = sh_q.busy && tick_i && (sh_q.sub == SUB_LAST);
        frame_end_o = bit_done && (sh_q.left == LEN_W'(1));

        if (sh_q.busy && tick_i) begin
            if (bit_done) begin
                sh_d.sub   = '0;
                sh_d.frame = {1'b1, sh_q.frame[FRAME_W-1:1]};
                sh_d.left  = sh_q.left - LEN_W'(1);
                if (sh_q.left == LEN_W'(1)) begin
                    sh_d.busy = 1'b0;
                end
            end else begin
                sh_d.sub = sh_q.sub + SUB_W'(1);
            end
        end

        // A new frame replaces the state, even on the edge that ends the old one
        if (load_i) begin
            sh_d.busy  = 1'b1;
            sh_d.frame = load_frame_i;
            sh_d.left  = load_len_i;
            sh_d.sub   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '{busy: 1'b0, frame: '1, left: '0, sub: '0};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign txd_o  = sh_q.busy ? sh_q.frame[0] : 1'b1;
    assign busy_o = sh_q.busy;

    // An edge without a tick and without a load must not move the line
    AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.busy && !tick_i && !load_i) |=> $stable(txd_o)); // R5

endmodule

// File: rtl/stx_transmitter.sv
module stx_transmitter
    import stx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud16_en_i,
    input  logic [1:0]        cmd_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              two_stop_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              txd_o,
    output logic              tx_ready_o,
    output logic              tx_empty_o
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic              enabled;
        logic              hold_full;
        logic [DATA_W-1:0] hold_data;
    } tx_state_t;

    tx_state_t          st_d, st_q;
    logic               load_go;
    logic               sh_busy;
    logic               sh_frame_end;
    logic [FRAME_W-1:0] new_frame;
    logic [LEN_W-1:0]   new_len;
    logic               enabled_q;
    logic               hold_full_q;

    assign enabled_q   = st_q.enabled;
    assign hold_full_q = st_q.hold_full;

    always_comb begin
        st_d    = st_q;
        load_go = st_q.enabled && st_q.hold_full && (!sh_busy || sh_frame_end);

        if (load_go) begin
            st_d.hold_full = 1'b0;
        end
        if (st_q.enabled && !st_q.hold_full && wr_en_i) begin
            st_d.hold_full = 1'b1;
            st_d.hold_data = wr_data_i;
        end

        case (cmd_i)
            CMD_ENABLE:  st_d.enabled = 1'b1;
            CMD_DISABLE: begin
                st_d.enabled   = 1'b0;
                st_d.hold_full = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{enabled: 1'b0, hold_full: 1'b0, hold_data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    stx_frame_builder #(
        .DATA_W  (DATA_W),
        .FRAME_W (FRAME_W),
        .LEN_W   (LEN_W)
    ) i_builder (
        .data_i     (st_q.hold_data),
        .par_en_i   (par_en_i),
        .par_odd_i  (par_odd_i),
        .two_stop_i (two_stop_i),
        .frame_o    (new_frame),
        .len_o      (new_len)
    );

    stx_shifter #(
        .FRAME_W    (FRAME_W),
        .LEN_W      (LEN_W),
        .OVERSAMPLE (OVERSAMPLE)
    ) i_shifter (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (baud16_en_i),
        .load_i       (load_go),
        .load_frame_i (new_frame),
        .load_len_i   (new_len),
        .txd_o        (txd_o),
        .busy_o       (sh_busy),
        .frame_end_o  (sh_frame_end)
    );

    assign tx_ready_o = st_q.enabled && !st_q.hold_full;
    assign tx_empty_o = st_q.enabled && !st_q.hold_full && !sh_busy;

    AST_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && tx_ready_o) |=> !tx_ready_o); // R3

    AST_HOLD_TO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full_q && enabled_q && !sh_busy) |=> (sh_busy && !hold_full_q)); // R4

    AST_DISABLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_DISABLE) |=> (!tx_ready_o && !tx_empty_o)); // R8

    AST_EMPTY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_empty_o) && $past(enabled_q)) |-> $past(sh_frame_end)); // R7

    AST_EMPTY_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_o |-> txd_o); // R10

endmodule

// File: tb/test_stx_transmitter.sv
module test_stx_transmitter;

    localparam int DW = 5;
    localparam int OS = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          baud16_en;
    logic [1:0]    cmd;
    logic          par_en, par_odd, two_stop;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic          txd, rdy, emp;

    int n_checks = 0;
    int n_fail   = 0;
    int phase    = 0;
    bit last_en  = 1'b0;

    always #10 clk = ~clk;

    stx_transmitter #(.DATA_W(DW), .OVERSAMPLE(OS)) i_stx_transmitter (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud16_en_i (baud16_en),
        .cmd_i       (cmd),
        .par_en_i    (par_en),
        .par_odd_i   (par_odd),
        .two_stop_i  (two_stop),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .txd_o       (txd),
        .tx_ready_o  (rdy),
        .tx_empty_o  (emp)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance to the next falling edge; last_en tells whether the rising edge just passed carried a tick.
    task automatic cycle();
        @(negedge clk);
        last_en   = baud16_en;
        phase     = (phase + 1) % 2;
        baud16_en = (phase == 0);
    endtask

    task automatic send_cmd(input logic [1:0] c);
        cmd = c;
        cycle();
        cmd = 2'b00;
    endtask

    task automatic do_write(input logic [DW-1:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        cycle();
        wr_en   = 1'b0;
    endtask

    function automatic logic exp_bit(input int k, input logic [DW-1:0] d, input bit pe, input bit po);
        if (k == 0) return 1'b0;
        if (k <= DW) return d[k-1];
        if (pe && k == DW + 1) return (^d) ^ po;
        return 1'b1;
    endfunction

    // Call at the first falling edge after the load edge.
    task automatic rx_frame(input logic [DW-1:0] d, input bit pe, input bit po, input bit ts,
                            input int wr_at, input logic [DW-1:0] wv,
                            input bit wr2, input logic [DW-1:0] wv2,
                            input int dis_at, input bit follow, input bit exp_empty);
        int t = 0;
        int len = 2 + DW + int'(pe) + int'(ts);
        for (int k = 0; k < len; k++) begin
            while (t < OS * k + OS / 2) begin
                cycle();
                if (last_en) t++;
            end
            chk($sformatf("R5 bit %0d of 0x%0h", k, d), int'(txd), int'(exp_bit(k, d, pe, po)));
            if (k == 0) chk("R7 empty low while shifting", int'(emp), 0);
            if (k == wr_at) begin
                wr_en = 1'b1; wr_data = wv;
                cycle(); if (last_en) t++;
                wr_en = 1'b0;
                chk("R3 ready low after write", int'(rdy), 0);
                chk("R7 empty low with char held", int'(emp), 0);
            end
            if (wr2 && k == wr_at + 2) begin
                wr_en = 1'b1; wr_data = wv2;
                cycle(); if (last_en) t++;
                wr_en = 1'b0;
                chk("R3 ready stays low after dropped write", int'(rdy), 0);
            end
            if (k == dis_at) begin
                cmd = 2'b10;
                cycle(); if (last_en) t++;
                cmd = 2'b00;
                chk("R8 ready low after disable", int'(rdy), 0);
                chk("R8 empty low after disable", int'(emp), 0);
            end
        end
        while (t < OS * len - 1) begin
            cycle();
            if (last_en) t++;
        end
        chk("R7 empty low in last tick of stop", int'(emp), 0);
        while (t < OS * len) begin
            cycle();
            if (last_en) t++;
        end
        if (follow) begin
            chk("R6 next start bit without gap", int'(txd), 0);
            chk("R4 ready back after transfer", int'(rdy), 1);
        end else begin
            chk("R10 line high after frame", int'(txd), 1);
            chk("R7 empty after final stop", int'(emp), int'(exp_empty));
        end
    endtask

    initial begin
        bit line_ok;
        rst_n = 1'b0; cmd = 2'b00; wr_en = 1'b0; wr_data = '0;
        par_en = 1'b0; par_odd = 1'b0; two_stop = 1'b0; baud16_en = 1'b0;
        repeat (3) cycle();
        rst_n = 1'b1;
        cycle();
        chk("R1 txd after reset", int'(txd), 1);
        chk("R1 ready after reset", int'(rdy), 0);
        chk("R1 empty after reset", int'(emp), 0);

        // Write while disabled is dropped
        do_write(5'h15);
        line_ok = 1'b1;
        repeat (80) begin cycle(); if (txd !== 1'b1) line_ok = 1'b0; end
        chk("R8 line idle after write while disabled", int'(line_ok), 1);
        chk("R8 ready low while disabled", int'(rdy), 0);

        send_cmd(2'b01);
        chk("R2 ready after enable", int'(rdy), 1);
        chk("R2 empty after enable", int'(emp), 1);
        line_ok = 1'b1;
        repeat (80) begin cycle(); if (txd !== 1'b1) line_ok = 1'b0; end
        chk("R8 dropped char never sent", int'(line_ok), 1);
        send_cmd(2'b11);
        chk("R2 code 11 keeps ready", int'(rdy), 1);
        send_cmd(2'b00);
        chk("R2 code 00 keeps empty", int'(emp), 1);

        // Sweep every character over all six formats
        for (int fmt = 0; fmt < 6; fmt++) begin
            par_en   = (fmt % 3) != 0;
            par_odd  = (fmt % 3) == 2;
            two_stop = fmt >= 3;
            for (int d = 0; d < (1 << DW); d++) begin
                do_write(DW'(d));
                chk("R3 ready low after write", int'(rdy), 0);
                cycle();
                chk("R4 ready after load", int'(rdy), 1);
                chk("R4 start bit at load", int'(txd), 0);
                rx_frame(DW'(d), par_en, par_odd, two_stop, -1, '0, 1'b0, '0, -1, 1'b0, 1'b1);
                cycle();
            end
        end

        // Back-to-back frames; the write made while full is dropped
        par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b0;
        do_write(5'h0B);
        cycle();
        rx_frame(5'h0B, 1'b1, 1'b0, 1'b0, 2, 5'h14, 1'b1, 5'h1F, -1, 1'b1, 1'b0);
        rx_frame(5'h14, 1'b1, 1'b0, 1'b0, -1, '0, 1'b0, '0, -1, 1'b0, 1'b1);
        repeat (4) cycle();

        // Disable mid-frame: frame completes, then idle
        do_write(5'h06);
        cycle();
        rx_frame(5'h06, 1'b1, 1'b0, 1'b0, -1, '0, 1'b0, '0, 3, 1'b0, 1'b0);
        line_ok = 1'b1;
        repeat (80) begin cycle(); if (txd !== 1'b1) line_ok = 1'b0; end
        chk("R9 line idle after disabled frame", int'(line_ok), 1);
        send_cmd(2'b01);
        chk("R2 re-enable ready", int'(rdy), 1);

        // Held character discarded on disable
        do_write(5'h19);
        cycle();
        rx_frame(5'h19, 1'b1, 1'b0, 1'b0, 1, 5'h0A, 1'b0, '0, 4, 1'b0, 1'b0);
        line_ok = 1'b1;
        repeat (400) begin cycle(); if (txd !== 1'b1) line_ok = 1'b0; end
        chk("R8 held char discarded", int'(line_ok), 1);
        send_cmd(2'b01);
        chk("R2 ready after enable", int'(rdy), 1);
        chk("R2 empty after enable", int'(emp), 1);

        summary();
        $finish;
    end

endmodule